// File: doc/BRIEF.md
# Two-Stage System Watchdog Timer

This block is a countdown watchdog on a small register bus. Software programs a timer value and then periodically writes the reload register (a "kick") to restart the countdown. The counter decrements once for every pulse on the `tick` input, so the timeout period is set jointly by the tick rate and the programmed value. When software fails to kick in time, the block escalates in two stages. The first expiry raises a one-cycle system-management interrupt request (if enabled) and sets a sticky status flag. A second expiry without an intervening kick requests a system reset, unless a no-reboot control bit, set by default, inhibits it.

The behaviour is a two-state machine. In STAGE1 the block counts toward its first timeout. The transition STAGE1 -> STAGE2 ("first expiry") sets the status flag, pulses SMI when enabled and reloads the counter. The transition STAGE2 -> STAGE1 ("reset issued") happens on a second expiry with reboot allowed, and pulses the reset request. The self-loop STAGE2 -> STAGE2 ("inhibited expiry") happens on a second expiry with no-reboot set, and pulses only SMI. The transition "kick" goes from either state to STAGE1 on any write to the reload register.

The registers occupy a 32-byte window of byte offsets. Offset 0x00 is the reload register, which reads back the live count. Offset 0x04 holds the timer value. Offset 0x08 is status. Offset 0x0C is control. Reads are combinational while `bus_rd` is high.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset the control register (0x0C) reads 0x00000020 (no-reboot bit 5 set, SMI enable bit 13 clear, halt bit 0 clear), the timer value (0x04) and the count (0x00) read TMR_RST, and status (0x08) reads 0.
- R2: While halt is clear, each cycle with `tick` high decrements the count by one. A read of offset 0x00 returns the current count.
- R3: A tick that arrives while the count is 0 is an expiry. The counter then reloads from the timer value, so the period is timer value + 1 ticks.
- R4: An expiry in STAGE1 sets status bit 0 (sticky first-timeout flag) and moves to STAGE2. Status bit 1 reads 1 exactly while in STAGE2.
- R5: Every expiry gives a single-cycle `smi_req` pulse in the cycle after the expiring tick, if and only if control bit 13 is set.
- R6: An expiry in STAGE2 with control bit 5 clear gives a single-cycle `rst_req` pulse in the same cycle an SMI would appear, and returns to STAGE1.
- R7: With control bit 5 set, no expiry ever asserts `rst_req`, and a second expiry leaves the block in STAGE2.
- R8: A write of any data to offset 0x00 reloads the count from the timer value and returns to STAGE1. This takes priority over a tick in the same cycle.
- R9: Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. A simultaneous expiry sets it.
- R10: While control bit 0 (halt) is set, ticks do not change the count and cause no expiry.
- R11: Reads of offsets other than 0x00, 0x04, 0x08 and 0x0C return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Byte offset within the register window |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, read data valid in the same cycle |
| bus_rdata | output | 32 | Read data, zero when bus_rd is low |
| tick | input | 1 | Countdown rate pulse |
| smi_req | output | 1 | Single-cycle SMI request pulse |
| rst_req | output | 1 | Single-cycle system reset request pulse |

## Verification
The assertions check on every cycle that an SMI pulse only follows a tick while SMI is enabled, that a reset pulse only leaves STAGE2 with reboot allowed, that no-reboot always blocks it, that a kick reloads the count and the stage, and that halt freezes the count. The bench scenarios cover the behaviours that need a longer history. These are the exact period from kick to first and second expiry, the sticky status flag and its write-one-to-clear, kick-and-tick collisions, SMI-disabled escalation, and the silent unimplemented offsets.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [0:0] {
        WD_STAGE1 = 1'b0,
        WD_STAGE2 = 1'b1
    } wd_stage_t;

    localparam int WIN_AW = 5;

    localparam logic [WIN_AW-1:0] OFF_KICK = 5'h00;
    localparam logic [WIN_AW-1:0] OFF_TMR  = 5'h04;
    localparam logic [WIN_AW-1:0] OFF_STS  = 5'h08;
    localparam logic [WIN_AW-1:0] OFF_CTL  = 5'h0C;

    localparam int CTL_HALT_BIT  = 0;
    localparam int CTL_NOREB_BIT = 5;
    localparam int CTL_SMIEN_BIT = 13;

endpackage

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int TMR_RST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             kick,
    input  logic             halt,
    input  logic             smi_en,
    input  logic             no_reboot,
    input  logic [CNT_W-1:0] tmr_val,
    output logic [CNT_W-1:0] cnt,
    output wd_stage_t        stage,
    output logic             first_to,
    output logic             smi_pulse,
    output logic             rst_pulse
);

    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(TMR_RST);

    wd_stage_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             step;
    logic             expire;

    assign step   = tick && !halt && !kick;
    assign expire = step && (cnt_q == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_STAGE1: begin
                if (kick)        state_d = WD_STAGE1;
                else if (expire) state_d = WD_STAGE2;
            end
            WD_STAGE2: begin
                if (kick)                      state_d = WD_STAGE1;
                else if (expire && !no_reboot) state_d = WD_STAGE1;
            end
            default: state_d = WD_STAGE1;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_STAGE1;
        else        state_q <= state_d;
    end

    // countdown
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= CNT_INIT;
        else if (kick)   cnt_q <= tmr_val;
        else if (expire) cnt_q <= tmr_val;
        else if (step)   cnt_q <= cnt_q - 1'b1;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smi_pulse <= 1'b0;
            rst_pulse <= 1'b0;
        end else begin
            smi_pulse <= expire && smi_en;
            rst_pulse <= expire && (state_q == WD_STAGE2) && !no_reboot;
        end
    end

    assign first_to = expire && (state_q == WD_STAGE1);
    assign cnt      = cnt_q;
    assign stage    = state_q;

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int TMR_RST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIN_AW-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              wr,
    input  logic              rd,
    output logic [31:0]       rdata,
    input  logic              first_to,
    input  logic [CNT_W-1:0]  cnt,
    input  wd_stage_t         stage,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              halt,
    output logic              no_reboot,
    output logic              smi_en,
    output logic              kick
);

    localparam logic [CNT_W-1:0] TMR_INIT = CNT_W'(TMR_RST);

    logic sts_first_q;
    logic wr_tmr, wr_sts, wr_ctl;

    assign kick   = wr && (addr == OFF_KICK);
    assign wr_tmr = wr && (addr == OFF_TMR);
    assign wr_sts = wr && (addr == OFF_STS);
    assign wr_ctl = wr && (addr == OFF_CTL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_val   <= TMR_INIT;
            halt      <= 1'b0;
            no_reboot <= 1'b1;
            smi_en    <= 1'b0;
        end else begin
            if (wr_tmr) tmr_val <= wdata[CNT_W-1:0];
            if (wr_ctl) begin
                halt      <= wdata[CTL_HALT_BIT];
                no_reboot <= wdata[CTL_NOREB_BIT];
                smi_en    <= wdata[CTL_SMIEN_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_first_q <= 1'b0;
        else        sts_first_q <= (sts_first_q && !(wr_sts && wdata[0])) || first_to;
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            case (addr)
                OFF_KICK: rdata[CNT_W-1:0] = cnt;
                OFF_TMR:  rdata[CNT_W-1:0] = tmr_val;
                OFF_STS: begin
                    rdata[0] = sts_first_q;
                    rdata[1] = (stage == WD_STAGE2);
                end
                OFF_CTL: begin
                    rdata[CTL_HALT_BIT]  = halt;
                    rdata[CTL_NOREB_BIT] = no_reboot;
                    rdata[CTL_SMIEN_BIT] = smi_en;
                end
                default: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
    import wdt_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int TMR_RST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIN_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    input  logic              tick,
    output logic              smi_req,
    output logic              rst_req
);

    logic [CNT_W-1:0] tmr_val_w;
    logic [CNT_W-1:0] cnt_w;
    wd_stage_t        stage_w;
    logic             halt_w, noreb_w, smien_w, kick_w, first_w;

    wdt_regs #(.CNT_W(CNT_W), .TMR_RST(TMR_RST)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .rdata     (bus_rdata),
        .first_to  (first_w),
        .cnt       (cnt_w),
        .stage     (stage_w),
        .tmr_val   (tmr_val_w),
        .halt      (halt_w),
        .no_reboot (noreb_w),
        .smi_en    (smien_w),
        .kick      (kick_w)
    );

    wdt_core #(.CNT_W(CNT_W), .TMR_RST(TMR_RST)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .kick      (kick_w),
        .halt      (halt_w),
        .smi_en    (smien_w),
        .no_reboot (noreb_w),
        .tmr_val   (tmr_val_w),
        .cnt       (cnt_w),
        .stage     (stage_w),
        .first_to  (first_w),
        .smi_pulse (smi_req),
        .rst_pulse (rst_req)
    );

endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
    import wdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             smi_req,
    input logic             rst_req,
    input logic             kick,
    input logic             halt,
    input logic             smi_en,
    input logic             no_reboot,
    input wd_stage_t        stage,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] tmr_val
);

    // R5
    smi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |-> ($past(tick) && $past(smi_en)));

    // R6
    rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ($past(stage) == WD_STAGE2 && !$past(no_reboot) && stage == WD_STAGE1));

    // R7
    noreboot_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        no_reboot |=> !rst_req);

    // R8
    kick_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt == $past(tmr_val) && stage == WD_STAGE1));

    // R10
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !kick) |=> ($stable(cnt) && !smi_req && !rst_req));

endmodule

bind wdt_two_stage wdt_chk #(.CNT_W(CNT_W)) u_wdt_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .smi_req   (smi_req),
    .rst_req   (rst_req),
    .kick      (kick_w),
    .halt      (halt_w),
    .smi_en    (smien_w),
    .no_reboot (noreb_w),
    .stage     (stage_w),
    .cnt       (cnt_w),
    .tmr_val   (tmr_val_w)
);

// File: tb/tb_wdt_two_stage.sv
module tb_wdt_two_stage;

    localparam int CNT_W   = 16;
    localparam int TMR_RST = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        tick = 1'b0;
    logic        smi_req, rst_req;

    int checks = 0;
    int failures = 0;
    int exp_q[$];

    always #10 clk = ~clk;

    wdt_two_stage #(.CNT_W(CNT_W), .TMR_RST(TMR_RST)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .tick(tick), .smi_req(smi_req), .rst_req(rst_req)
    );

    // monitor: pulse code = {rst_req, smi_req}
    always @(negedge clk) begin
        if (rst_n && (smi_req || rst_req)) begin
            int got;
            got = {30'd0, rst_req, smi_req};
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R5/R6/R7 unexpected pulse: actual=%0d expected=none", got);
            end else begin
                int want;
                want = exp_q.pop_front();
                if (got != want) begin
                    failures++;
                    $display("FAIL R5/R6/R7 pulse: actual=%0d expected=%0d", got, want);
                end
            end
        end
    end

    task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            failures++;
            $display("FAIL %s read 0x%02h: actual=0x%08h expected=0x%08h", req, a, bus_rdata, exp);
        end
        bus_rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic expect_pulse(input int code);
        exp_q.push_back(code);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset defaults
        rd_chk(5'h0C, 32'h0000_0020, "R1");
        rd_chk(5'h04, TMR_RST, "R1");
        rd_chk(5'h00, TMR_RST, "R1");
        rd_chk(5'h08, 32'h0, "R1");

        // R8 program and kick, R2 decrement
        wr_reg(5'h04, 32'd2);
        wr_reg(5'h00, 32'h0000_DEAD);
        rd_chk(5'h00, 32'd2, "R8");
        wr_reg(5'h0C, 32'h0000_2020);
        ticks(1);
        rd_chk(5'h00, 32'd1, "R2");

        // R3/R4/R5 first expiry
        expect_pulse(1);
        ticks(2);
        rd_chk(5'h08, 32'd3, "R4");
        rd_chk(5'h00, 32'd2, "R3");

        // R7 second expiry inhibited
        expect_pulse(1);
        ticks(3);
        rd_chk(5'h08, 32'd3, "R7");

        // R9 write-one-to-clear
        wr_reg(5'h08, 32'd0);
        rd_chk(5'h08, 32'd3, "R9");
        wr_reg(5'h08, 32'd1);
        rd_chk(5'h08, 32'd2, "R9");

        // R6 full escalation with reboot allowed
        wr_reg(5'h0C, 32'h0000_2000);
        wr_reg(5'h00, 32'd0);
        rd_chk(5'h08, 32'd0, "R8");
        expect_pulse(1);
        ticks(3);
        expect_pulse(3);
        ticks(3);
        rd_chk(5'h08, 32'd1, "R6");

        // R8 kicks prevent expiry; kick wins over tick
        wr_reg(5'h08, 32'd1);
        wr_reg(5'h00, 32'd0);
        ticks(2);
        rd_chk(5'h00, 32'd0, "R2");
        @(negedge clk);
        bus_addr = 5'h00; bus_wdata = 32'd7; bus_wr = 1'b1; tick = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick = 1'b0;
        rd_chk(5'h00, 32'd2, "R8");
        ticks(2);
        wr_reg(5'h00, 32'd0);
        ticks(2);
        rd_chk(5'h08, 32'd0, "R8");

        // R10 halt freezes count
        wr_reg(5'h0C, 32'h0000_2001);
        ticks(5);
        rd_chk(5'h00, 32'd0, "R10");
        rd_chk(5'h08, 32'd0, "R10");

        // R5 SMI disabled: silent first expiry, reset-only second
        wr_reg(5'h0C, 32'h0000_0000);
        wr_reg(5'h00, 32'd0);
        ticks(3);
        rd_chk(5'h08, 32'd3, "R5");
        expect_pulse(2);
        ticks(3);
        rd_chk(5'h08, 32'd1, "R6");

        // R11 unimplemented offsets
        wr_reg(5'h10, 32'hFFFF_FFFF);
        wr_reg(5'h1C, 32'hFFFF_FFFF);
        rd_chk(5'h10, 32'd0, "R11");
        rd_chk(5'h1C, 32'd0, "R11");
        rd_chk(5'h0C, 32'd0, "R11");
        rd_chk(5'h04, 32'd2, "R11");
        rd_chk(5'h08, 32'd1, "R11");

        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R5/R6 missing pulses: actual=%0d pending expected=0", exp_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule